// File: doc/BRIEF.md
# Intersection Signal Phase Controller

This block sequences the lamps of a crossing of two roads, north–south (NS) and east–west (EW). It cycles through four phases: NS green, NS yellow, EW green and EW yellow. The road that is not moving shows red. Each road has its own seconds counter, and both counters are exposed as 6-bit binary values for a countdown display. A clock divider makes a one-cycle tick once per second, and every state change happens on that tick.

An emergency request is passed through a two-flop synchronizer. While it is active, both roads show red and the phase and both counters stay frozen. Any tick that arrives during that time is discarded. When the request drops, the controller carries on from exactly the phase and counts it held. An active-low asynchronous reset returns the block to its start phase and overrides the emergency input.

Top module: `sig_phase_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the NS lamp is green, the EW lamp is red, the NS count is 20 and the EW count is 25.
- R2: Each lamp output is one-hot: 3'b001 means green, 3'b010 means yellow and 3'b100 means red.
- R3: The phases run in the order NS green/EW red, NS yellow/EW red, NS red/EW green, NS red/EW yellow, and then back to the first phase.
- R4: On a tick without a hold, both counts drop by one while the governing count is above 1. The NS count governs the two NS phases and the EW count governs the two EW phases.
- R5: When the governing count is 1, the tick changes the phase and does not decrement. Entering NS yellow sets NS to 5. Entering EW green sets NS to 25 and EW to 20. Entering EW yellow sets EW to 5. Returning to NS green sets NS to 20 and EW to 25. A count that is not reloaded keeps its value.
- R6: A tick is produced every TICK_DIV clock cycles, and one full cycle of phases lasts 50 ticks. With the default divider that is 50,000,000 cycles per tick.
- R7: While the synchronized emergency is active, both lamps show 3'b100 and neither count nor the phase changes.
- R8: Once the synchronized emergency clears, the phase and both counts are the same as during the hold, and normal ticking resumes from them.
- R9: Reset takes priority over emergency. Asserting reset while emergency is high still produces the R1 state.
- R10: The emergency input takes effect at the lamps two clock edges after it is sampled, and it is released two edges after it drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| emerg_i | input | 1 | Emergency request, asynchronous |
| ns_lamp_o | output | 3 | NS lamp, one-hot green/yellow/red |
| ew_lamp_o | output | 3 | EW lamp, one-hot green/yellow/red |
| ns_count_o | output | 6 | NS seconds remaining |
| ew_count_o | output | 6 | EW seconds remaining |

## Verification
Two situations can land on the same clock edge, and both are provoked on purpose. The first is the start of an emergency hold coinciding with a tick, including a tick that would change the phase. The bench raises the request at a different offset from the divider in each of several episodes, and it varies the hold length. The tick on the edge where the synchronized hold first goes high must be dropped, and the edge where the hold clears must also leave the state unchanged. Both cases are judged against a cycle-accurate model kept in the bench. The second situation is reset arriving in the middle of a hold, and the bench checks that the start state wins.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [3:0] {
    PH_NSG = 4'b0001,
    PH_NSY = 4'b0010,
    PH_EWG = 4'b0100,
    PH_EWY = 4'b1000
  } phase_e;

  localparam logic [2:0] LAMP_G = 3'b001;
  localparam logic [2:0] LAMP_Y = 3'b010;
  localparam logic [2:0] LAMP_R = 3'b100;
endpackage

// File: rtl/sp_tick_gen.sv
module sp_tick_gen #(
  parameter int unsigned DIV = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == LAST);

      p_tick_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
      p_cnt_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);
    end else begin : g_pass
      assign tick_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/sp_phase_fsm.sv
module sp_phase_fsm
  import sp_pkg::*;
#(
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned GREEN_T  = 20,
  parameter int unsigned YELLOW_T = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  output logic [2:0]       ns_lamp_o,
  output logic [2:0]       ew_lamp_o,
  output logic [CNT_W-1:0] ns_cnt_o,
  output logic [CNT_W-1:0] ew_cnt_o
);
  localparam int unsigned RED_T = GREEN_T + YELLOW_T;
  localparam logic [CNT_W-1:0] C_GRN = CNT_W'(GREEN_T);
  localparam logic [CNT_W-1:0] C_YEL = CNT_W'(YELLOW_T);
  localparam logic [CNT_W-1:0] C_RED = CNT_W'(RED_T);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

  phase_e          phase_q, phase_d;
  logic [CNT_W-1:0] ns_q, ns_d, ew_q, ew_d;
  logic            adv;

  assign adv = tick_i && !hold_i;

  always_comb begin
    phase_d = phase_q;
    ns_d    = ns_q;
    ew_d    = ew_q;
    case (phase_q)
      PH_NSG: if (adv) begin
        if (ns_q > C_ONE) begin ns_d = ns_q - 1'b1; ew_d = ew_q - 1'b1; end
        else begin phase_d = PH_NSY; ns_d = C_YEL; end
      end
      PH_NSY: if (adv) begin
        if (ns_q > C_ONE) begin ns_d = ns_q - 1'b1; ew_d = ew_q - 1'b1; end
        else begin phase_d = PH_EWG; ns_d = C_RED; ew_d = C_GRN; end
      end
      PH_EWG: if (adv) begin
        if (ew_q > C_ONE) begin ns_d = ns_q - 1'b1; ew_d = ew_q - 1'b1; end
        else begin phase_d = PH_EWY; ew_d = C_YEL; end
      end
      PH_EWY: if (adv) begin
        if (ew_q > C_ONE) begin ns_d = ns_q - 1'b1; ew_d = ew_q - 1'b1; end
        else begin phase_d = PH_NSG; ns_d = C_GRN; ew_d = C_RED; end
      end
      default: begin
        // corrupted phase register: restart cleanly
        phase_d = PH_NSG;
        ns_d    = C_GRN;
        ew_d    = C_RED;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_NSG;
      ns_q    <= C_GRN;
      ew_q    <= C_RED;
    end else begin
      phase_q <= phase_d;
      ns_q    <= ns_d;
      ew_q    <= ew_d;
    end
  end

  always_comb begin
    ns_lamp_o = LAMP_R;
    ew_lamp_o = LAMP_R;
    if (!hold_i) begin
      case (phase_q)
        PH_NSG:  ns_lamp_o = LAMP_G;
        PH_NSY:  ns_lamp_o = LAMP_Y;
        PH_EWG:  ew_lamp_o = LAMP_G;
        PH_EWY:  ew_lamp_o = LAMP_Y;
        default: ;
      endcase
    end
  end

  assign ns_cnt_o = ns_q;
  assign ew_cnt_o = ew_q;

  p_lamp_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ns_lamp_o) == 1 && $countones(ew_lamp_o) == 1);
  p_one_road_moves_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_lamp_o == LAMP_R || ew_lamp_o == LAMP_R);
  p_idle_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(ns_q) && $stable(ew_q) && $stable(phase_q));
  p_cnt_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_q != '0 && ew_q != '0);
  p_nsy_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_NSY && $past(phase_q) != PH_NSY) |-> ns_q == C_YEL);
  p_ewg_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EWG && $past(phase_q) != PH_EWG) |-> (ns_q == C_RED && ew_q == C_GRN));
  p_hold_red_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> (ns_lamp_o == LAMP_R && ew_lamp_o == LAMP_R));
  p_hold_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(ns_q) && $stable(ew_q) && $stable(phase_q));
endmodule

// File: rtl/sig_phase_ctrl.sv
module sig_phase_ctrl #(
  parameter int unsigned TICK_DIV    = 50_000_000,
  parameter int unsigned GREEN_T     = 20,
  parameter int unsigned YELLOW_T    = 5,
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             emerg_i,
  output logic [2:0]       ns_lamp_o,
  output logic [2:0]       ew_lamp_o,
  output logic [CNT_W-1:0] ns_count_o,
  output logic [CNT_W-1:0] ew_count_o
);
  logic tick;
  logic hold;

  sp_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  sp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (emerg_i),
    .q_o   (hold)
  );

  sp_phase_fsm #(
    .CNT_W   (CNT_W),
    .GREEN_T (GREEN_T),
    .YELLOW_T(YELLOW_T)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .hold_i   (hold),
    .ns_lamp_o(ns_lamp_o),
    .ew_lamp_o(ew_lamp_o),
    .ns_cnt_o (ns_count_o),
    .ew_cnt_o (ew_count_o)
  );
endmodule

// File: tb/sim_sig_phase_ctrl.sv
module sim_sig_phase_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       emerg = 1'b0;
  logic [2:0] ns_lamp, ew_lamp;
  logic [5:0] ns_cnt, ew_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit run_cmp = 0;

  sig_phase_ctrl #(.TICK_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .emerg_i(emerg),
    .ns_lamp_o(ns_lamp), .ew_lamp_o(ew_lamp),
    .ns_count_o(ns_cnt), .ew_count_o(ew_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model written from the requirements
  int m_div, m_ph, m_ns, m_ew;
  bit m_s1, m_s2, m_rel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_ph = 0; m_ns = 20; m_ew = 25; m_s1 = 0; m_s2 = 0; m_rel = 0;
    end else begin
      bit tk;
      tk = (m_div == DIV - 1);
      m_div = tk ? 0 : m_div + 1;
      m_rel = 0;
      if (tk && !m_s2) begin
        int gov;
        gov = (m_ph < 2) ? m_ns : m_ew;
        if (gov > 1) begin m_ns--; m_ew--; end
        else begin
          m_rel = 1;
          case (m_ph)
            0: begin m_ph = 1; m_ns = 5; end
            1: begin m_ph = 2; m_ns = 25; m_ew = 20; end
            2: begin m_ph = 3; m_ew = 5; end
            default: begin m_ph = 0; m_ns = 20; m_ew = 25; end
          endcase
        end
      end
      m_s2 = m_s1;
      m_s1 = emerg;
    end
  end

  function automatic int exp_ns_lamp();
    if (m_s2) return 4;
    return (m_ph == 0) ? 1 : (m_ph == 1) ? 2 : 4;
  endfunction
  function automatic int exp_ew_lamp();
    if (m_s2) return 4;
    return (m_ph == 2) ? 1 : (m_ph == 3) ? 2 : 4;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      chk("R2 ns onehot", $countones(ns_lamp), 1);
      chk("R2 ew onehot", $countones(ew_lamp), 1);
      chk(m_s2 ? "R7 ns lamp" : "R3 ns lamp", int'(ns_lamp), exp_ns_lamp());
      chk(m_s2 ? "R7 ew lamp" : "R3 ew lamp", int'(ew_lamp), exp_ew_lamp());
      chk(m_s2 ? "R7 ns cnt" : (m_rel ? "R5 ns cnt" : "R4 ns cnt"), int'(ns_cnt), m_ns);
      chk(m_s2 ? "R7 ew cnt" : (m_rel ? "R5 ew cnt" : "R4 ew cnt"), int'(ew_cnt), m_ew);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_start(string tag);
    chk({tag, " ns lamp"}, int'(ns_lamp), 1);
    chk({tag, " ew lamp"}, int'(ew_lamp), 4);
    chk({tag, " ns cnt"}, int'(ns_cnt), 20);
    chk({tag, " ew cnt"}, int'(ew_cnt), 25);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int sn, se;
    step(3);
    chk_start("R1 in reset");
    rst_n = 1'b1;
    run_cmp = 1;
    step(1);
    chk_start("R1 after release");
    // R6: 49 ticks reach the last EW yellow second, the 50th wraps
    step(198);
    chk("R6 ew cnt at 49 ticks", int'(ew_cnt), 1);
    chk("R6 ew lamp at 49 ticks", int'(ew_lamp), 2);
    step(1);
    chk_start("R6 wrap at 50 ticks");

    for (int e = 0; e < 12; e++) begin
      step(e * 11 + 5);
      emerg = 1'b1;
      step(1);
      chk("R10 not held after one edge", int'(ns_lamp == 3'b100 && ew_lamp == 3'b100), 0);
      step(1);
      chk("R10 held after two edges", int'(ns_lamp == 3'b100 && ew_lamp == 3'b100), 1);
      sn = ns_cnt; se = ew_cnt;
      step(e % 5 + 3 * DIV);
      chk("R7 ns frozen", int'(ns_cnt), sn);
      chk("R7 ew frozen", int'(ew_cnt), se);
      emerg = 1'b0;
      step(1);
      chk("R10 still held one edge after drop", int'(ns_lamp == 3'b100 && ew_lamp == 3'b100), 1);
      step(1);
      chk("R8 ns resumed", int'(ns_cnt), sn);
      chk("R8 ew resumed", int'(ew_cnt), se);
      chk("R8 ns lamp", int'(ns_lamp), exp_ns_lamp());
      chk("R8 ew lamp", int'(ew_lamp), exp_ew_lamp());
    end

    emerg = 1'b1;
    step(23);
    run_cmp = 0;
    #1 rst_n = 1'b0;
    #1 chk_start("R9 reset over emergency");
    step(2);
    chk_start("R9 held in reset");
    rst_n = 1'b1;
    run_cmp = 1;
    step(1);
    chk_start("R9 after release");
    step(4);
    emerg = 1'b0;
    step(260);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule